// File: doc/BRIEF.md
# BCD Calendar Clock Core

This block holds the time of day and the calendar as packed BCD registers and moves them forward once per second. The second is produced by a prescaler that counts enable pulses from a slow timebase, nominally 32768 Hz or 32000 Hz. Which of the two rates applies is selected by a bit in the trim register. A signed trim code can stretch or shorten one second out of every `TRIM_SECS` seconds, which corrects the average rate without touching the timebase itself.

Software, or a serial bridge placed in front of the block, reads and writes the registers through a single parallel port. The hour register works in either 24-hour or 12-hour (AM/PM) form. After reset the clock is frozen by a stop flag, which stands for "oscillator lost power". It starts counting only once that flag is written to zero.

Top module: `bcd_clock_core`

## Requirements
- R1: After reset the registers read: seconds 0x00, minutes 0x00, hours 0x12 (12 AM), weekday 0x00, day 0x01, month 0x01, year 0x00, trim 0x00, control 0x10 (stop flag set, 12-hour mode).
- R2: Register indices are: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month, 6 year, 7 trim, 8 control. Writes keep only the defined bits, with masks 0x7F, 0x7F, 0x3F, 0x07, 0x3F, 0x9F, 0xFF, 0xFF. Control keeps bit 5 (1 = 24-hour) and bit 4 (stop). Indices 9 to 15 read 0x00 and writes to them change nothing.
- R3: While the stop flag (control bit 4) is 1, the time does not advance and `sec_tick_o` stays low. Writing it to 0 starts the clock, and the first tick comes after one full period of enables.
- R4: Trim bit 7 = 0 gives a second of `TB_A` timebase enables, and bit 7 = 1 gives `TB_B`. Cycles where `tb_en_i` is low are not counted.
- R5: A write to any of indices 0 to 7 clears the prescaler. The next tick follows exactly one period of enables after that write.
- R6: Seconds and minutes count 00 to 59 in BCD. Each wraps to 00 and carries into the next field.
- R7: In 24-hour mode the hour counts 00 to 23. The step from 23 to 00 advances the day.
- R8: In 12-hour mode bit 5 is PM and bits 4:0 hold BCD 01 to 12. The order is 12 AM (0x12), 01 AM, up to 11 AM, then 12 PM (0x32), 01 PM (0x21), up to 11 PM (0x31), then 12 AM with a day advance.
- R9: The weekday counts 0 to 6, wraps to 0, and steps at every day advance.
- R10: The day wraps to 01 after the last day of the month. April, June, September and November have 30 days. February has 29 days when the BCD year is a multiple of 4, and 28 otherwise. All other months have 31.
- R11: The month wraps from 12 to 01 and advances the year. The year wraps from 99 to 00 and toggles the century bit (month bit 7).
- R12: A trim code (bits 6:0, bit 6 = sign) whose bits 5:1 are all zero changes nothing. Otherwise every `TRIM_SECS`-th second, counted from the last write to index 0 to 7, is adjusted by 2m-1 enables. With sign 0 the second is lengthened and m = bits 5:0. With sign 1 it is shortened and m = 64 - bits 5:0.
- R13: `sec_tick_o` is a one-cycle pulse. When it is high, the registers already show the advanced time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tb_en_i | input | 1 | One pulse per timebase period |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | 4 | Write register index |
| wr_data_i | input | 8 | Write data |
| rd_idx_i | input | 4 | Read register index |
| rd_data_o | output | 8 | Read data for `rd_idx_i`, combinational |
| sec_tick_o | output | 1 | One-cycle pulse per elapsed second |

## Verification
The hardest state to reach from the ports is a cascade that runs through every field at once: a year rollover on New Year's Eve, or a leap-day boundary, where a single tick touches seven fields. Waiting for such a date to arrive is out of reach. The bench therefore loads dates directly at or near their rollover points, with about half the fields biased to their limits, and compares the next tick against a binary-arithmetic model. Trim is reached by counting enables across several consecutive seconds after a trim write. One run uses a randomly gated timebase, so the period is measured in enables rather than in cycles.

// File: rtl/bcd_clk_pkg.sv
package bcd_clk_pkg;

  localparam int unsigned IDX_W = 4;
  localparam logic [IDX_W-1:0] IDX_SEC  = 4'd0;
  localparam logic [IDX_W-1:0] IDX_MIN  = 4'd1;
  localparam logic [IDX_W-1:0] IDX_HOUR = 4'd2;
  localparam logic [IDX_W-1:0] IDX_WDAY = 4'd3;
  localparam logic [IDX_W-1:0] IDX_DAY  = 4'd4;
  localparam logic [IDX_W-1:0] IDX_MON  = 4'd5;
  localparam logic [IDX_W-1:0] IDX_YEAR = 4'd6;
  localparam logic [IDX_W-1:0] IDX_TRIM = 4'd7;
  localparam logic [IDX_W-1:0] IDX_CTRL = 4'd8;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] mon;
    logic [7:0] day;
    logic [7:0] wday;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } cal_t;

  localparam cal_t CAL_RST = '{year: 8'h00, mon: 8'h01, day: 8'h01, wday: 8'h00,
                               hour: 8'h12, min: 8'h00, sec: 8'h00};

  function automatic logic [7:0] wr_mask(input logic [IDX_W-1:0] idx);
    case (idx)
      IDX_SEC, IDX_MIN: return 8'h7F;
      IDX_HOUR, IDX_DAY: return 8'h3F;
      IDX_WDAY: return 8'h07;
      IDX_MON: return 8'h9F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] >= 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  // {carry, next}: wraps to init once the limit is reached
  function automatic logic [8:0] bcd_wrap(input logic [7:0] v, input logic [7:0] lim,
                                          input logic [7:0] init);
    return (v >= lim) ? {1'b1, init} : {1'b0, bcd_inc(v)};
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
    logic leap;
    leap = (!yr[4] && (yr[3:0] == 4'd0 || yr[3:0] == 4'd4 || yr[3:0] == 4'd8)) ||
           ( yr[4] && (yr[3:0] == 4'd2 || yr[3:0] == 4'd6));
    case (mon[4:0])
      5'h02: return leap ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/bcd_clk_prescaler.sv
module bcd_clk_prescaler
  import bcd_clk_pkg::*;
#(
  parameter int unsigned TB_A      = 32768,
  parameter int unsigned TB_B      = 32000,
  parameter int unsigned TRIM_SECS = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       run_i,
  input  logic       clr_i,
  input  logic [7:0] trim_i,
  output logic       adv_o
);
  localparam int unsigned MAX_PER = ((TB_A > TB_B) ? TB_A : TB_B) + 127;
  localparam int unsigned CNT_W   = $clog2(MAX_PER + 1);
  localparam int unsigned SEC_W   = $clog2(TRIM_SECS + 1);

  logic [CNT_W-1:0] cnt_q, base, per;
  logic [SEC_W-1:0] sec_q;
  logic [6:0]       mag;
  logic [7:0]       adj;
  logic             trim_on, adj_sec;

  always_comb begin
    trim_on = |trim_i[5:1];
    mag     = trim_i[6] ? (7'd64 - {1'b0, trim_i[5:0]}) : {1'b0, trim_i[5:0]};
    adj     = {mag, 1'b0} - 8'd1;
    adj_sec = trim_on && (sec_q == SEC_W'(TRIM_SECS - 1));
    base    = trim_i[7] ? CNT_W'(TB_B) : CNT_W'(TB_A);
    if (!adj_sec)       per = base;
    else if (trim_i[6]) per = base - CNT_W'(adj);
    else                per = base + CNT_W'(adj);
    // >= so a shorter period after a trim change still terminates
    adv_o = en_i && run_i && !clr_i && (cnt_q >= per - CNT_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sec_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
      sec_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
    end else if (en_i) begin
      if (adv_o) begin
        cnt_q <= '0;
        sec_q <= (sec_q == SEC_W'(TRIM_SECS - 1)) ? '0 : sec_q + SEC_W'(1);
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  p_hold_when_stopped_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0 && !adv_o));

  p_count_bounded_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_PER));

endmodule

// File: rtl/bcd_clk_calendar.sv
module bcd_clk_calendar
  import bcd_clk_pkg::*;
(
  input  cal_t cur_i,
  input  logic mode24_i,
  output cal_t nxt_o
);
  logic       c_s, c_m, c_h, c_d, c_mo, c_y, pm;
  logic [7:0] lo, lo_inc, mlo;

  always_comb begin
    nxt_o = cur_i;
    c_m = 1'b0; c_h = 1'b0; c_d = 1'b0; c_mo = 1'b0; c_y = 1'b0;
    pm = cur_i.hour[5];
    lo = {3'b000, cur_i.hour[4:0]};
    lo_inc = bcd_inc(lo);
    mlo = 8'h00;

    {c_s, nxt_o.sec} = bcd_wrap(cur_i.sec, 8'h59, 8'h00);
    if (c_s) {c_m, nxt_o.min} = bcd_wrap(cur_i.min, 8'h59, 8'h00);
    if (c_m) begin
      if (mode24_i) begin
        {c_h, nxt_o.hour} = bcd_wrap({2'b00, cur_i.hour[5:0]}, 8'h23, 8'h00);
      end else if (lo == 8'h11) begin
        nxt_o.hour = {2'b00, ~pm, 5'h12};   // 11 -> 12 flips AM/PM
        c_h = pm;
      end else if (lo >= 8'h12) begin
        nxt_o.hour = {2'b00, pm, 5'h01};
      end else begin
        nxt_o.hour = {2'b00, pm, lo_inc[4:0]};
      end
    end
    if (c_h) begin
      nxt_o.wday = (cur_i.wday[2:0] >= 3'd6) ? 8'h00 : {5'b0, cur_i.wday[2:0] + 3'd1};
      {c_d, nxt_o.day} = bcd_wrap(cur_i.day, month_len(cur_i.mon, cur_i.year), 8'h01);
    end
    if (c_d) begin
      {c_mo, mlo} = bcd_wrap({3'b000, cur_i.mon[4:0]}, 8'h12, 8'h01);
      nxt_o.mon = {cur_i.mon[7], 2'b00, mlo[4:0]};
    end
    if (c_mo) {c_y, nxt_o.year} = bcd_wrap(cur_i.year, 8'h99, 8'h00);
    if (c_y) nxt_o.mon[7] = ~cur_i.mon[7];
  end

endmodule

// File: rtl/bcd_clock_core.sv
module bcd_clock_core
  import bcd_clk_pkg::*;
#(
  parameter int unsigned TB_A      = 32768,
  parameter int unsigned TB_B      = 32000,
  parameter int unsigned TRIM_SECS = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tb_en_i,
  input  logic       wr_en_i,
  input  logic [3:0] wr_idx_i,
  input  logic [7:0] wr_data_i,
  input  logic [3:0] rd_idx_i,
  output logic [7:0] rd_data_o,
  output logic       sec_tick_o
);
  cal_t       cal_q, cal_nxt;
  logic [7:0] trim_q;
  logic       mode24_q, stop_q, tick_q, adv, time_wr, pre_clr;

  assign time_wr = wr_en_i && (wr_idx_i <= IDX_YEAR);
  assign pre_clr = wr_en_i && (wr_idx_i <= IDX_TRIM);

  bcd_clk_prescaler #(.TB_A(TB_A), .TB_B(TB_B), .TRIM_SECS(TRIM_SECS)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tb_en_i),
    .run_i  (!stop_q),
    .clr_i  (pre_clr),
    .trim_i (trim_q),
    .adv_o  (adv)
  );

  bcd_clk_calendar u_cal (
    .cur_i    (cal_q),
    .mode24_i (mode24_q),
    .nxt_o    (cal_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cal_q    <= CAL_RST;
      trim_q   <= 8'h00;
      mode24_q <= 1'b0;
      stop_q   <= 1'b1;
      tick_q   <= 1'b0;
    end else begin
      tick_q <= adv;
      if (time_wr) begin
        case (wr_idx_i)
          IDX_SEC:  cal_q.sec  <= wr_data_i & wr_mask(IDX_SEC);
          IDX_MIN:  cal_q.min  <= wr_data_i & wr_mask(IDX_MIN);
          IDX_HOUR: cal_q.hour <= wr_data_i & wr_mask(IDX_HOUR);
          IDX_WDAY: cal_q.wday <= wr_data_i & wr_mask(IDX_WDAY);
          IDX_DAY:  cal_q.day  <= wr_data_i & wr_mask(IDX_DAY);
          IDX_MON:  cal_q.mon  <= wr_data_i & wr_mask(IDX_MON);
          default:  cal_q.year <= wr_data_i;
        endcase
      end else if (adv) begin
        cal_q <= cal_nxt;
      end
      if (wr_en_i && wr_idx_i == IDX_TRIM) trim_q <= wr_data_i;
      if (wr_en_i && wr_idx_i == IDX_CTRL) begin
        mode24_q <= wr_data_i[5];
        stop_q   <= wr_data_i[4];
      end
    end
  end

  always_comb begin
    case (rd_idx_i)
      IDX_SEC:  rd_data_o = cal_q.sec;
      IDX_MIN:  rd_data_o = cal_q.min;
      IDX_HOUR: rd_data_o = cal_q.hour;
      IDX_WDAY: rd_data_o = cal_q.wday;
      IDX_DAY:  rd_data_o = cal_q.day;
      IDX_MON:  rd_data_o = cal_q.mon;
      IDX_YEAR: rd_data_o = cal_q.year;
      IDX_TRIM: rd_data_o = trim_q;
      IDX_CTRL: rd_data_o = {2'b00, mode24_q, stop_q, 4'b0000};
      default:  rd_data_o = 8'h00;
    endcase
  end

  assign sec_tick_o = tick_q;

  p_stop_freezes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_q && !wr_en_i) |=> $stable(cal_q));

  p_sec_bcd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && !wr_en_i && cal_q.sec[3:0] <= 4'd9 && cal_q.sec[6:4] <= 3'd5)
    |=> (cal_q.sec[3:0] <= 4'd9 && cal_q.sec[6:4] <= 3'd5));

  p_hour24_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && !wr_en_i && mode24_q && cal_q.hour <= 8'h23 && cal_q.hour[3:0] <= 4'd9)
    |=> (cal_q.hour <= 8'h23));

  p_hour12_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && !wr_en_i && !mode24_q && cal_q.hour[4:0] >= 5'h01 && cal_q.hour[4:0] <= 5'h12
     && cal_q.hour[3:0] <= 4'd9)
    |=> (cal_q.hour[4:0] >= 5'h01 && cal_q.hour[4:0] <= 5'h12));

  p_wday_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && !wr_en_i && cal_q.wday <= 8'h06) |=> (cal_q.wday <= 8'h06));

  p_century_on_wrap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(wr_en_i) && cal_q.mon[7] != $past(cal_q.mon[7])) |-> (cal_q.year == 8'h00));

  p_tick_single_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |=> !sec_tick_o);

endmodule

// File: tb/bcd_clock_core_tb_top.sv
`timescale 1ns/1ps
module bcd_clock_core_tb_top;
  localparam int TA = 400;
  localparam int TB = 300;
  localparam int TS = 4;

  typedef logic [6:0][7:0] tv_t;

  logic       clk = 1'b0, rst_n = 1'b0, tb_en = 1'b1, wr_en = 1'b0;
  logic [3:0] wr_idx = '0, rd_idx = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic       tick;
  int         errs = 0, checks = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  bcd_clock_core #(.TB_A(TA), .TB_B(TB), .TRIM_SECS(TS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tb_en_i(tb_en), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .rd_idx_i(rd_idx), .rd_data_o(rd_data), .sec_tick_o(tick));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input int data);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_data = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int idx, output int v);
    rd_idx = 4'(idx);
    #0.2;
    v = int'(rd_data);
  endtask

  // counts enables seen by the DUT until the tick pulse shows at a falling edge
  task automatic wait_tick(input bit rnd, output int n);
    int cyc = 0;
    n = 0;
    forever begin
      tb_en = rnd ? 1'($urandom % 2) : 1'b1;
      n += int'(tb_en);
      @(negedge clk);
      cyc++;
      if (tick) break;
      if (cyc > 4000) begin n = -1; break; end
    end
    tb_en = 1'b1;
  endtask

  function automatic int b2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input int n);
    return {4'(n / 10), 4'(n % 10)};
  endfunction

  function automatic int mdays(input int m, input int y);
    case (m)
      2: return (y % 4 == 0) ? 29 : 28;
      4, 6, 9, 11: return 30;
      default: return 31;
    endcase
  endfunction

  function automatic logic [7:0] hr_enc(input int h, input bit m24);
    int hh;
    if (m24) return i2b(h);
    hh = h % 12;
    if (hh == 0) hh = 12;
    return ((h >= 12) ? 8'h20 : 8'h00) | i2b(hh);
  endfunction

  function automatic tv_t mk(input int s, input int mi, input int h, input int w, input int d,
                             input int mo, input int y, input bit cen, input bit m24);
    tv_t t;
    t[0] = i2b(s); t[1] = i2b(mi); t[2] = hr_enc(h, m24); t[3] = 8'(w);
    t[4] = i2b(d); t[5] = i2b(mo) | (cen ? 8'h80 : 8'h00); t[6] = i2b(y);
    return t;
  endfunction

  function automatic tv_t model_next(input tv_t t, input bit m24);
    int s, mi, h, w, d, mo, y;
    bit cen;
    s = b2i(t[0]); mi = b2i(t[1]);
    if (m24) h = b2i(t[2] & 8'h3F);
    else     h = (b2i(t[2] & 8'h1F) % 12) + (t[2][5] ? 12 : 0);
    w = int'(t[3]); d = b2i(t[4]); mo = b2i(t[5] & 8'h1F); cen = t[5][7]; y = b2i(t[6]);
    s++;
    if (s == 60) begin
      s = 0; mi++;
      if (mi == 60) begin
        mi = 0; h++;
        if (h == 24) begin
          h = 0; w = (w + 1) % 7; d++;
          if (d > mdays(mo, y)) begin
            d = 1; mo++;
            if (mo == 13) begin
              mo = 1; y++;
              if (y == 100) begin y = 0; cen = !cen; end
            end
          end
        end
      end
    end
    return mk(s, mi, h, w, d, mo, y, cen, m24);
  endfunction

  task automatic check_all(input tv_t e, input string req);
    int v;
    for (int i = 0; i < 7; i++) begin
      rd(i, v);
      chk(req, v, int'(e[i]));
    end
  endtask

  // set mode, load a time, wait one second, compare against model
  task automatic step_check(input tv_t t, input bit m24, input string req);
    int n;
    wr(8, m24 ? 8'h20 : 8'h00);
    for (int i = 0; i < 7; i++) wr(i, int'(t[i]));
    wait_tick(1'b0, n);
    chk("R5 first tick after load", n, TA);
    check_all(model_next(t, m24), req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int v, n, seen;
    int unsigned seed_v;
    seed_v = $urandom(20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    begin
      int exp_rst[9] = '{8'h00, 8'h00, 8'h12, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h10};
      for (int i = 0; i < 9; i++) begin rd(i, v); chk("R1 reset value", v, exp_rst[i]); end
    end

    // R3 frozen after reset
    seen = 0;
    repeat (1000) begin @(negedge clk); if (tick) seen++; end
    chk("R3 no tick while stopped", seen, 0);
    rd(0, v); chk("R3 seconds frozen", v, 8'h00);

    // R2 write masks and unmapped index
    for (int i = 0; i < 8; i++) wr(i, 8'hFF);
    wr(9, 8'hFF);
    begin
      int exp_m[8] = '{8'h7F, 8'h7F, 8'h3F, 8'h07, 8'h3F, 8'h9F, 8'hFF, 8'hFF};
      for (int i = 0; i < 8; i++) begin rd(i, v); chk("R2 write mask", v, exp_m[i]); end
    end
    rd(9, v); chk("R2 unmapped reads zero", v, 0);
    rd(8, v); chk("R2 control untouched by index 9", v, 8'h10);
    wr(7, 8'h00);

    // R3 start, then stop again
    wr(8, 8'h20);
    wait_tick(1'b0, n); chk("R3 first tick after start", n, TA);
    wr(8, 8'h30);
    rd(0, v);
    seen = 0;
    repeat (2 * TA) begin @(negedge clk); if (tick) seen++; end
    chk("R3 no tick after stop", seen, 0);
    rd(0, n); chk("R3 seconds held", n, v);

    // directed rollovers
    step_check(mk(59, 59, 23, 6, 31, 12, 99, 0, 1), 1'b1, "R11 year wrap century");
    @(negedge clk); chk("R13 tick is one cycle", int'(tick), 0);
    step_check(mk(59, 59, 23, 3, 15, 6, 10, 1, 1), 1'b1, "R7 hour 23 wrap");
    step_check(mk(59, 12, 5, 2, 15, 6, 10, 0, 1), 1'b1, "R6 seconds carry");
    step_check(mk(59, 59, 23, 1, 28, 2, 24, 0, 1), 1'b1, "R10 Feb 28 leap");
    step_check(mk(59, 59, 23, 1, 29, 2, 24, 0, 1), 1'b1, "R10 Feb 29 leap");
    step_check(mk(59, 59, 23, 1, 28, 2, 23, 0, 1), 1'b1, "R10 Feb 28 common");
    step_check(mk(59, 59, 23, 6, 30, 4, 7, 0, 1), 1'b1, "R9 R10 Apr 30 wday wrap");
    step_check(mk(59, 59, 23, 2, 31, 12, 41, 0, 1), 1'b1, "R11 month wrap");
    step_check(mk(59, 59, 11, 0, 9, 3, 5, 0, 0), 1'b0, "R8 11AM to 12PM");
    step_check(mk(59, 59, 23, 0, 9, 3, 5, 0, 0), 1'b0, "R8 11PM to 12AM");
    step_check(mk(59, 59, 0, 0, 9, 3, 5, 0, 0), 1'b0, "R8 12AM to 1AM");
    step_check(mk(59, 59, 12, 0, 9, 3, 5, 0, 0), 1'b0, "R8 12PM to 1PM");

    // random dates biased to limits
    for (int it = 0; it < 60; it++) begin
      bit m24;
      int s, mi, h, mo, y, d;
      m24 = 1'($urandom % 2);
      s  = ($urandom % 2) ? 59 : int'($urandom % 60);
      mi = ($urandom % 2) ? 59 : int'($urandom % 60);
      h  = ($urandom % 3 == 0) ? 23 : (($urandom % 3 == 0) ? 11 : int'($urandom % 24));
      mo = 1 + int'($urandom % 12);
      y  = ($urandom % 2) ? 99 : int'($urandom % 100);
      d  = ($urandom % 2) ? mdays(mo, y) : 1 + int'($urandom % 28);
      step_check(mk(s, mi, h, int'($urandom % 7), d, mo, y, 1'($urandom % 2), m24), m24,
                 "R6 R7 R8 R9 R10 R11 random");
    end

    // R4 timebase select and gated enables
    wr(7, 8'h80);
    wait_tick(1'b0, n); chk("R4 second timebase", n, TB);
    wait_tick(1'b0, n); chk("R4 second timebase repeat", n, TB);
    wr(7, 8'h00);
    wait_tick(1'b1, n); chk("R4 gated enables", n, TA);

    // R5 write mid-second restarts the prescaler
    repeat (123) @(negedge clk);
    wr(0, 8'h10);
    wait_tick(1'b0, n); chk("R5 restart after write", n, TA);

    // R12 trim
    wr(7, 8'h05);
    for (int i = 0; i < 2 * TS; i++) begin
      wait_tick(1'b0, n); chk("R12 lengthen m=5", n, (i % TS == TS - 1) ? TA + 9 : TA);
    end
    wr(7, 8'h7E);
    for (int i = 0; i < TS; i++) begin
      wait_tick(1'b0, n); chk("R12 shorten m=2", n, (i == TS - 1) ? TA - 3 : TA);
    end
    wr(7, 8'h41);
    for (int i = 0; i < TS; i++) begin
      wait_tick(1'b0, n); chk("R12 inactive code", n, TA);
    end
    wr(7, 8'hBF);
    for (int i = 0; i < TS; i++) begin
      wait_tick(1'b0, n); chk("R12 max lengthen on second timebase", n, (i == TS - 1) ? TB + 125 : TB);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule